// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block is the master side of a three-wire serial EEPROM link of the 93Cxx kind. It drives chip select, a serial clock and a serial data line into the part, and it reads the part's serial data output. Each request carries one of five operations: read, write, erase, write-enable or write-disable. The request also carries an address and a 16-bit data word. The block frames the request as a start bit, a two-bit opcode, the address and any data. It returns read data with a one-cycle done pulse. Write and erase requests end with a ready poll.

After reset the block first runs a probe with no request from the user. The probe finds out whether the attached part decodes 6 or 8 address bits. Every later frame uses the width found. When a write or erase frame has been sent, the controller drops chip select briefly and then raises it again. It then samples the part's output until the output reads high. If the output never goes high within a parameter-set number of samples, the request completes with an error flag.

Top module: `uwire_eeprom_master`

## Requirements
- R1: While the synchronous reset is high, `ee_cs`, `ee_sk`, `ee_di`, `done` and `error` are 0 and `busy` is 1.
- R2: When reset is released, a width probe runs without any request, and `busy` stays high until it ends. The probe sends the bits 1,1,0 and then ones, and stops after the sixth address bit. It samples `ee_do` on that sixth address clock. A low sample sets `addr_wide`=0 (6-bit part) and a high sample sets `addr_wide`=1 (8-bit part). The probe ends with a done pulse and error 0.
- R3: `req_op` selects the frame. 0 is read and sends 1,1,0. 1 is write and sends 1,0,1. 2 is erase and sends 1,1,1. 3 is write-enable: it sends 1,0,0 and then an address field whose two top bits are 1 and whose other bits are 0. 4 is write-disable: it sends 1,0,0 and then an all-zero address field. The address is the low 6 or 8 bits of `req_addr`, sent MSB first; upper bits of `req_addr` have no effect on a 6-bit part. A write then sends `req_wdata` MSB first.
- R4: A read gives 16 more clocks after the address. `ee_do` is sampled on each of them, MSB first, into `rdata`. `rdata` is valid when `done` pulses and changes only on reads.
- R5: `ee_sk` stays high for exactly HALF_CLKS cycles each time. `ee_di` changes only while `ee_sk` is low and holds steady through every high phase.
- R6: `ee_cs` rises only while `ee_sk` is low. `ee_sk` is never high while `ee_cs` is low. `ee_cs` is low whenever `busy` is low.
- R7: After the last bit of a write or erase, `ee_cs` goes low for one half-period and then high again. `ee_do` is then sampled once per half-period. The first high sample drops `ee_cs` and ends the request with `error`=0.
- R8: If POLL_MAX samples in a row are all low, the request ends with `error`=1. `error` is only ever high together with `done`.
- R9: A `req_valid` pulse while `busy` is high is dropped. It is neither executed nor queued.
- R10: `done` is a one-cycle pulse in the cycle where `busy` falls. The next request can be taken in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while busy is low |
| req_op | input | 3 | Operation code (0 read, 1 write, 2 erase, 3 write-enable, 4 write-disable) |
| req_addr | input | ADDR_MAX | Word address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Probe or request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Ready-poll timeout, valid with done |
| rdata | output | DATA_W | Last read word |
| addr_wide | output | 1 | Probe result: 1 for 8 address bits, 0 for 6 |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |

## Verification
A bit counter that is off by one shifts every later address and data bit. The first read-back after a full sweep of writes then gives wrong words, on the first mismatched address. A wrong probe sample gives a frame of the wrong length. The part then decodes garbage, and every read in the sweep after the probe fails. A poll state that is stuck or misses a ready edge shows up at once: either a spurious error arrives with the next write's done, or the timeout request finishes clean. A request that leaks through while busy shows as an extra chip select burst, or as a changed word on the read that follows.

// File: rtl/uwm_pkg.sv
`timescale 1ns/1ps
package uwm_pkg;

  typedef enum logic [2:0] {
    UWM_READ  = 3'd0,
    UWM_WRITE = 3'd1,
    UWM_ERASE = 3'd2,
    UWM_WREN  = 3'd3,
    UWM_WRDIS = 3'd4
  } uwm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_POLL,
    ST_END
  } uwm_state_e;

endpackage

// File: rtl/uwm_tick.sv
`timescale 1ns/1ps
// Half-period strobe for the serial clock: one pulse every HALF_CLKS cycles
// while run is high, restarting from zero each time run rises.
module uwm_tick #(
  parameter int HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/uwm_frame.sv
`timescale 1ns/1ps
// Builds the outgoing bit frame, MSB aligned, plus bit counts for one access.
module uwm_frame
  import uwm_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_MIN = 6,
  parameter int ADDR_MAX = 8,
  localparam int FW = 3 + ADDR_MAX + DATA_W,
  localparam int CW = $clog2(FW + 1)
) (
  input  uwm_op_e             op,
  input  logic [ADDR_MAX-1:0] addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                wide,
  input  logic                probe,
  output logic [FW-1:0]       frame,
  output logic [CW-1:0]       n_out,
  output logic [CW-1:0]       n_in,
  output logic                need_poll
);
  int                  aw;
  logic [2:0]          cmd;
  logic [ADDR_MAX-1:0] amask;
  logic [ADDR_MAX-1:0] afld;
  logic                with_data;

  always_comb begin
    aw        = (probe || wide) ? ADDR_MAX : ADDR_MIN;
    amask     = ADDR_MAX'((1 << aw) - 1);
    cmd       = 3'b110;
    afld      = addr & amask;
    with_data = 1'b0;
    need_poll = 1'b0;
    n_in      = '0;
    if (probe) begin
      afld = amask;
    end else begin
      case (op)
        UWM_READ:  begin cmd = 3'b110; n_in = CW'(DATA_W); end
        UWM_WRITE: begin cmd = 3'b101; with_data = 1'b1; need_poll = 1'b1; end
        UWM_ERASE: begin cmd = 3'b111; need_poll = 1'b1; end
        UWM_WREN:  begin cmd = 3'b100; afld = ADDR_MAX'(3) << (aw - 2); end
        UWM_WRDIS: begin cmd = 3'b100; afld = '0; end
        default:   begin cmd = 3'b110; n_in = CW'(DATA_W); end
      endcase
    end

    frame = FW'(cmd) << (FW - 3);
    frame = frame | (FW'(afld) << (FW - 3 - aw));
    if (with_data)
      frame = frame | (FW'(wdata) << (FW - 3 - aw - DATA_W));

    if (probe) n_out = CW'(3 + ADDR_MIN);
    else       n_out = CW'(3 + aw + (with_data ? DATA_W : 0));
  end
endmodule

// File: rtl/uwm_seq.sv
`timescale 1ns/1ps
// Access sequencer: chip select framing, bit shifting, ready polling.
module uwm_seq
  import uwm_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_MAX = 10000,
  parameter int FW       = 27,
  parameter int CW       = 5,
  localparam int PW = $clog2(POLL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              req_valid,
  input  logic [FW-1:0]     frame,
  input  logic [CW-1:0]     n_out,
  input  logic [CW-1:0]     n_in,
  input  logic              need_poll,
  input  logic              ee_do,
  output logic              probing,
  output logic              active,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [DATA_W-1:0] rdata,
  output logic              wide,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di
);
  uwm_state_e        state;
  logic [FW-1:0]     shreg;
  logic [CW-1:0]     left;
  logic [CW-1:0]     n_in_q;
  logic              poll_q;
  logic              probe_q;
  logic              probe_pend;
  logic              err_q;
  logic [PW-1:0]     pcnt;
  logic [DATA_W-1:0] rd_sh;

  assign probing = probe_pend;
  assign active  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      left       <= '0;
      n_in_q     <= '0;
      poll_q     <= 1'b0;
      probe_q    <= 1'b0;
      probe_pend <= 1'b1;
      err_q      <= 1'b0;
      pcnt       <= '0;
      rd_sh      <= '0;
      busy       <= 1'b1;
      done       <= 1'b0;
      error      <= 1'b0;
      rdata      <= '0;
      wide       <= 1'b0;
      ee_cs      <= 1'b0;
      ee_sk      <= 1'b0;
      ee_di      <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (probe_pend || req_valid) begin
            shreg      <= frame << 1;
            ee_di      <= frame[FW-1];
            left       <= n_out + n_in;
            n_in_q     <= n_in;
            poll_q     <= need_poll && !probe_pend;
            probe_q    <= probe_pend;
            probe_pend <= 1'b0;
            err_q      <= 1'b0;
            ee_cs      <= 1'b1;
            ee_sk      <= 1'b0;
            busy       <= 1'b1;
            state      <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            ee_sk <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            if (left <= n_in_q)
              rd_sh <= {rd_sh[DATA_W-2:0], ee_do};
            left  <= left - 1'b1;
            ee_sk <= 1'b0;
            if (left == CW'(1)) begin
              if (probe_q) wide <= ee_do;
              ee_cs <= 1'b0;
              ee_di <= 1'b0;
              state <= poll_q ? ST_GAP : ST_END;
            end else begin
              ee_di <= shreg[FW-1];
              shreg <= shreg << 1;
              state <= ST_LOW;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            ee_cs <= 1'b1;
            pcnt  <= '0;
            state <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (tick) begin
            if (ee_do) begin
              ee_cs <= 1'b0;
              state <= ST_END;
            end else if (pcnt == PW'(POLL_MAX - 1)) begin
              ee_cs <= 1'b0;
              err_q <= 1'b1;
              state <= ST_END;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        ST_END: begin
          if (tick) begin
            done  <= 1'b1;
            error <= err_q;
            busy  <= 1'b0;
            if (n_in_q != '0) rdata <= rd_sh;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uwire_eeprom_master.sv
`timescale 1ns/1ps
module uwire_eeprom_master
  import uwm_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_MIN  = 6,
  parameter int ADDR_MAX  = 8,
  parameter int HALF_CLKS = 4,
  parameter int POLL_MAX  = 10000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [2:0]          req_op,
  input  logic [ADDR_MAX-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                busy,
  output logic                done,
  output logic                error,
  output logic [DATA_W-1:0]   rdata,
  output logic                addr_wide,
  output logic                ee_cs,
  output logic                ee_sk,
  output logic                ee_di,
  input  logic                ee_do
);
  localparam int FW = 3 + ADDR_MAX + DATA_W;
  localparam int CW = $clog2(FW + 1);

  logic          tick;
  logic          active;
  logic          probing;
  logic [FW-1:0] frame;
  logic [CW-1:0] n_out;
  logic [CW-1:0] n_in;
  logic          need_poll;

  uwm_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .tick (tick)
  );

  uwm_frame #(
    .DATA_W   (DATA_W),
    .ADDR_MIN (ADDR_MIN),
    .ADDR_MAX (ADDR_MAX)
  ) u_frame (
    .op        (uwm_op_e'(req_op)),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .wide      (addr_wide),
    .probe     (probing),
    .frame     (frame),
    .n_out     (n_out),
    .n_in      (n_in),
    .need_poll (need_poll)
  );

  uwm_seq #(
    .DATA_W   (DATA_W),
    .POLL_MAX (POLL_MAX),
    .FW       (FW),
    .CW       (CW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .req_valid (req_valid),
    .frame     (frame),
    .n_out     (n_out),
    .n_in      (n_in),
    .need_poll (need_poll),
    .ee_do     (ee_do),
    .probing   (probing),
    .active    (active),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .rdata     (rdata),
    .wide      (addr_wide),
    .ee_cs     (ee_cs),
    .ee_sk     (ee_sk),
    .ee_di     (ee_di)
  );
endmodule

// File: rtl/uwm_checker.sv
`timescale 1ns/1ps
module uwm_checker #(
  parameter int HALF_CLKS = 4
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic error,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);
  logic [31:0] hi_len;

  always_ff @(posedge clk) begin
    if (rst)        hi_len <= '0;
    else if (ee_sk) hi_len <= hi_len + 1'b1;
    else            hi_len <= '0;
  end

  assert_sk_needs_cs_R6: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sk);

  assert_cs_rise_clock_low_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_cs) |-> !ee_sk);

  assert_idle_cs_low_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ee_cs);

  assert_di_steady_R5: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> $stable(ee_di));

  assert_sk_high_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_sk) |-> (hi_len == 32'(HALF_CLKS)));

  assert_error_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

bind uwire_eeprom_master uwm_checker #(.HALF_CLKS(HALF_CLKS)) u_uwm_chk (
  .clk   (clk),
  .rst   (rst),
  .busy  (busy),
  .done  (done),
  .error (error),
  .ee_cs (ee_cs),
  .ee_sk (ee_sk),
  .ee_di (ee_di)
);

// File: tb/test_uwire_eeprom_master.sv
`timescale 1ns/1ps
module test_uwire_eeprom_master;
  localparam int DW   = 16;
  localparam int AMIN = 6;
  localparam int AMAX = 8;
  localparam int HALF = 2;
  localparam int POLL = 50;
  localparam int WD_CYCLES = 190000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [2:0]      req_op = 3'd0;
  logic [AMAX-1:0] req_addr = '0;
  logic [DW-1:0]   req_wdata = '0;
  logic            busy, done, error, addr_wide;
  logic [DW-1:0]   rdata;
  logic            ee_cs, ee_sk, ee_di, ee_do;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  uwire_eeprom_master #(
    .DATA_W(DW), .ADDR_MIN(AMIN), .ADDR_MAX(AMAX),
    .HALF_CLKS(HALF), .POLL_MAX(POLL)
  ) i_uwire_eeprom_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .error(error), .rdata(rdata), .addr_wide(addr_wide),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  // ---------------- serial EEPROM model ----------------
  logic [15:0] mem [0:255];
  int          m_aw   = 8;
  int          m_blen = 40;
  logic        sk_q = 1'b0, cs_q = 1'b0;
  int          m_st = 0, m_cnt = 0, m_pend = 0, m_busy = 0;
  logic [1:0]  m_op = '0;
  logic [7:0]  m_adr = '0, na;
  logic [15:0] m_wd = '0;
  logic        m_drive = 1'b0, m_bit = 1'b0, m_status = 1'b0, m_wen = 1'b0;

  assign ee_do = m_drive ? m_bit : (m_status ? (m_busy == 0) : 1'b1);

  always @(posedge clk) begin
    sk_q <= ee_sk;
    cs_q <= ee_cs;
    if (m_busy > 0) m_busy <= m_busy - 1;
    if (rst) begin
      m_st <= 0; m_drive <= 1'b0; m_status <= 1'b0; m_pend <= 0;
      m_wen <= 1'b0; m_busy <= 0;
    end else if (!ee_cs) begin
      if (cs_q && m_pend != 0 && m_wen) begin
        if (m_pend == 1) mem[m_adr] <= m_wd;
        else             mem[m_adr] <= 16'hFFFF;
        m_busy <= m_blen;
      end
      m_pend <= 0; m_st <= 0; m_drive <= 1'b0; m_status <= 1'b0;
    end else begin
      if (!cs_q) m_status <= 1'b1;
      if (ee_sk && !sk_q) begin
        case (m_st)
          0: if (ee_di) begin
               m_st <= 1; m_cnt <= 0; m_status <= 1'b0; m_adr <= '0;
             end
          1: begin
               m_op <= {m_op[0], ee_di};
               if (m_cnt == 1) begin m_st <= 2; m_cnt <= 0; end
               else m_cnt <= m_cnt + 1;
             end
          2: begin
               na = {m_adr[6:0], ee_di};
               m_adr <= na;
               if (m_cnt == m_aw - 1) begin
                 m_cnt <= 0;
                 case (m_op)
                   2'b10: begin m_drive <= 1'b1; m_bit <= 1'b0; m_st <= 3; end
                   2'b01: m_st <= 4;
                   2'b11: begin m_pend <= 2; m_st <= 5; end
                   default: begin
                     if ((na >> (m_aw - 2)) == 8'd3) m_wen <= 1'b1;
                     else if ((na >> (m_aw - 2)) == 8'd0) m_wen <= 1'b0;
                     m_st <= 5;
                   end
                 endcase
               end else m_cnt <= m_cnt + 1;
             end
          3: begin
               m_bit <= mem[m_adr][15 - m_cnt];
               if (m_cnt == 15) m_st <= 5;
               m_cnt <= m_cnt + 1;
             end
          4: begin
               m_wd <= {m_wd[14:0], ee_di};
               if (m_cnt == 15) begin m_pend <= 1; m_st <= 5; end
               m_cnt <= m_cnt + 1;
             end
          default: ;
        endcase
      end
    end
  end

  // ---------------- pin protocol monitor (R5, R6) ----------------
  int   bad5 = 0, bad6 = 0, hi_run = 0;
  logic sk_p = 1'b0, cs_p = 1'b0, di_p = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ee_sk && !ee_cs) bad6++;
      if (ee_cs && !cs_p && ee_sk) bad6++;
      if (ee_sk && ee_di != di_p) bad5++;
      if (ee_sk) hi_run++;
      else begin
        if (sk_p && hi_run != HALF) bad5++;
        hi_run = 0;
      end
    end
    sk_p = ee_sk; cs_p = ee_cs; di_p = ee_di;
  end

  // ---------------- helpers ----------------
  logic [DW-1:0] got_rd;
  logic          got_err;

  function automatic logic [15:0] pat(input int a, input int aw);
    return 16'((a * 40503 + aw * 257) ^ 16'hA5C3);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input int op, input int addr, input logic [15:0] wd);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_op = op[2:0]; req_addr = addr[7:0]; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    got_rd = rdata; got_err = error;
    @(negedge clk);
    chk(!done && !busy, "R10 done single pulse", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic run_width(input int aw);
    int n;
    int hits;
    logic [15:0] exp;
    n = 1 << aw;
    m_aw = aw; m_blen = 40;
    rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di, "R1 pins idle in reset", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
    chk(!done && !error, "R1 flags clear in reset", {30'd0, done, error}, 32'd0);
    chk(busy, "R1 busy in reset", {31'd0, busy}, 32'd1);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(busy, "R2 probe runs after reset", {31'd0, busy}, 32'd1);
    while (busy) @(negedge clk);
    chk(addr_wide == (aw == 8), "R2 detected width", {31'd0, addr_wide}, (aw == 8) ? 32'd1 : 32'd0);

    issue(3, 0, 16'h0);
    for (int a = 0; a < n; a++) begin
      issue(1, a, pat(a, aw));
      chk(!got_err, "R7 write completes ready", {31'd0, got_err}, 32'd0);
    end
    for (int a = 0; a < n; a++) begin
      issue(0, a, 16'h0);
      chk(got_rd == pat(a, aw), "R4 R3 read after write", {16'd0, got_rd}, {16'd0, pat(a, aw)});
    end
    for (int a = 0; a < n; a += 8) begin
      issue(2, a, 16'h0);
      chk(!got_err, "R7 erase completes ready", {31'd0, got_err}, 32'd0);
    end
    for (int a = 0; a < n; a++) begin
      if (a % 8 < 2) begin
        exp = (a % 8 == 0) ? 16'hFFFF : pat(a, aw);
        issue(0, a, 16'h0);
        chk(got_rd == exp, "R3 erase opcode", {16'd0, got_rd}, {16'd0, exp});
      end
    end
    exp = (aw == 6) ? pat(5, aw) : pat(8'hC5, aw);
    issue(0, 8'hC5, 16'h0);
    chk(got_rd == exp, "R3 address field width", {16'd0, got_rd}, {16'd0, exp});

    // R9: a write pulsed during a read is dropped
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_op = 3'd0; req_addr = 8'd1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_addr = 8'd1; req_wdata = ~pat(1, aw);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(rdata == pat(1, aw), "R9 read unaffected", {16'd0, rdata}, {16'd0, pat(1, aw)});
    hits = 0;
    repeat (30) begin
      @(negedge clk);
      if (ee_cs || busy) hits++;
    end
    chk(hits == 0, "R9 request not queued", hits, 32'd0);
    issue(0, 1, 16'h0);
    chk(got_rd == pat(1, aw), "R9 memory unchanged", {16'd0, got_rd}, {16'd0, pat(1, aw)});

    issue(4, 0, 16'h0);
    issue(1, 2, 16'h1234);
    issue(0, 2, 16'h0);
    chk(got_rd == pat(2, aw), "R3 write-disable frame", {16'd0, got_rd}, {16'd0, pat(2, aw)});
    issue(3, 0, 16'h0);
    issue(1, 2, 16'h1234);
    issue(0, 2, 16'h0);
    chk(got_rd == 16'h1234, "R3 write-enable frame", {16'd0, got_rd}, 32'h1234);

    m_blen = 1000;
    issue(1, 3, 16'hBEEF);
    chk(got_err, "R8 poll timeout flags error", {31'd0, got_err}, 32'd1);
    m_blen = 40;
    repeat (1000) @(negedge clk);
    issue(2, 3, 16'h0);
    chk(!got_err, "R8 error cleared on next request", {31'd0, got_err}, 32'd0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog expired, run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    run_width(6);
    run_width(8);
    chk(bad5 == 0, "R5 clock and data timing", bad5, 32'd0);
    chk(bad6 == 0, "R6 chip select framing", bad6, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule